// File: doc/BRIEF.md
# Quarter-Rate Quadrature Mixer

This block shifts a real sampled signal whose band sits around one quarter of the sample rate down to complex baseband. It multiplies each incoming sample by a local oscillator fixed at fs/4. The oscillator has only four phase states, and every state takes one of the values 0, +1 or -1. Mixing is therefore done by passing the sample, negating it or forcing zero, and the block needs no multiplier.

The in-phase lane applies the cosine pattern +1, 0, -1, 0. The quadrature lane applies the negated sine pattern 0, -1, 0, +1. A two-bit phase counter selects the pattern entry. The counter moves forward only when a sample arrives, so idle cycles between samples do not disturb the oscillator. The I and Q results are registered. Their width is one bit more than the input width, so negating any input value fits without overflow. Low-pass filtering and decimation belong to the stage that follows.

Top module: `quad_mix_fs4`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_i and out_q are 0. The phase counter returns to state 0, so the first sample accepted after reset is mixed with phase 0.
- R2: out_valid is in_valid delayed by exactly one clock cycle.
- R3: For the n-th accepted sample x, counted from 0 after reset, out_i is +x, 0, -x, 0 for n mod 4 = 0, 1, 2, 3 respectively.
- R4: For the n-th accepted sample x, out_q is 0, -x, 0, +x for n mod 4 = 0, 1, 2, 3 respectively.
- R5: The phase advances only on cycles with in_valid high. Any number of idle cycles between two samples leaves the phase sequence unchanged.
- R6: In a slot whose oscillator value is 0, the lane output is exactly zero. It does not keep the previous value.
- R7: The outputs are IN_W+1 bits wide, signed. Negating the most negative input (-2^(IN_W-1)) gives +2^(IN_W-1) with no wrap.
- R8: On a cycle with in_valid low, out_i and out_q keep their values on the next cycle.
- R9: The phase wraps from state 3 to state 0 and the pattern repeats with period four samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_i | output | IN_W+1 | Signed in-phase result |
| out_q | output | IN_W+1 | Signed quadrature result |

## Verification
Every result is due one clock edge after the edge that accepts its sample: out_valid, out_i and out_q all appear after a single register stage. The bench drives inputs on the falling edge. It updates a behavioural model on the rising edge, using the inputs it just drove. It compares the model with the outputs on the next falling edge, so each comparison sees exactly the one-edge latency. Directed checks cover the boundary cases and read the result on the falling edge that follows the accepting edge: idle gaps, holding while idle, the most negative sample, and the phase wrap.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
    // Width of the oscillator phase index (four states)
    localparam int PH_W = 2;

    // Action applied to a sample by one oscillator value
    typedef enum logic [1:0] {
        W_ZERO = 2'd0,
        W_PASS = 2'd1,
        W_NEG  = 2'd2
    } weight_e;
endpackage

// File: rtl/qmix_lo.sv
// Oscillator table: phase state to lane actions (cosine on I, negated sine on Q)
module qmix_lo
    import qmix_pkg::*;
(
    input  logic [PH_W-1:0] phase,
    output weight_e         w_i,
    output weight_e         w_q
);
    always_comb begin
        unique case (phase)
            2'd0: begin w_i = W_PASS; w_q = W_ZERO; end
            2'd1: begin w_i = W_ZERO; w_q = W_NEG;  end
            2'd2: begin w_i = W_NEG;  w_q = W_ZERO; end
            default: begin w_i = W_ZERO; w_q = W_PASS; end
        endcase
    end
endmodule

// File: rtl/qmix_scale.sv
// Applies a 0/+1/-1 weight to one sample, widened by one bit
module qmix_scale
    import qmix_pkg::*;
#(
    parameter int IN_W = 12,
    localparam int OUT_W = IN_W + 1
) (
    input  weight_e                  w,
    input  logic signed [IN_W-1:0]   x,
    output logic signed [OUT_W-1:0]  y
);
    logic signed [OUT_W-1:0] ext;

    assign ext = {x[IN_W-1], x};

    always_comb begin
        unique case (w)
            W_PASS:  y = ext;
            W_NEG:   y = -ext;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/quad_mix_fs4.sv
module quad_mix_fs4
    import qmix_pkg::*;
#(
    parameter int IN_W = 12,
    localparam int OUT_W = IN_W + 1,
    localparam int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);
    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] i;
        logic signed [OUT_W-1:0] q;
        logic [PH_W-1:0]         ph;
    } state_t;

    state_t st_d, st_q;

    weight_e                 w_lane [LANES];
    logic signed [OUT_W-1:0] y_lane [LANES];

    qmix_lo u_lo (
        .phase (st_q.ph),
        .w_i   (w_lane[0]),
        .w_q   (w_lane[1])
    );

    // Lane 0 is in-phase, lane 1 is quadrature
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qmix_scale #(.IN_W(IN_W)) u_scale (
            .w (w_lane[g]),
            .x (in_sample),
            .y (y_lane[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.i  = y_lane[0];
            st_d.q  = y_lane[1];
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.i;
    assign out_q     = st_q.q;
endmodule

// File: rtl/quad_mix_fs4_chk.sv
module quad_mix_fs4_chk #(
    parameter int IN_W = 12,
    localparam int OUT_W = IN_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  in_sample,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q
);
    logic [1:0]              cnt_q;
    logic signed [OUT_W-1:0] ext;

    assign ext = {in_sample[IN_W-1], in_sample};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_valid) cnt_q <= cnt_q + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    i_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_q == 2'd0) |=> out_i == $past(ext));
    // R3 R7
    i_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_q == 2'd2) |=> out_i == -$past(ext));
    // R4 R7
    q_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_q == 2'd1) |=> out_q == -$past(ext));
    // R4 R9
    q_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_q == 2'd3) |=> out_q == $past(ext));
    // R6
    i_zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_q[0]) |=> out_i == '0);
    // R6
    q_zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_q[0]) |=> out_q == '0);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));
endmodule

bind quad_mix_fs4 quad_mix_fs4_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/quad_mix_fs4_test.sv
`timescale 1ns/1ps
module quad_mix_fs4_test;
    localparam int IN_W  = 12;
    localparam int OUT_W = IN_W + 1;
    localparam int MOST_NEG = -(2 ** (IN_W - 1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_sample = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_i;
    logic signed [OUT_W-1:0] out_q;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_ph = 0;
    int m_v = 0;
    int m_i = 0;
    int m_q = 0;

    always #5 clk = ~clk;

    quad_mix_fs4 #(.IN_W(IN_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input bit v, input int x);
        @(negedge clk);
        in_valid  = v;
        in_sample = IN_W'(x);
    endtask

    // reference model: oscillator cos for I, -sin for Q, phase moves per sample
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_v = 0; m_i = 0; m_q = 0;
        end else begin
            m_v = in_valid;
            if (in_valid) begin
                int x;
                x = int'(in_sample);
                case (m_ph)
                    0: begin m_i = x;  m_q = 0;  end
                    1: begin m_i = 0;  m_q = -x; end
                    2: begin m_i = -x; m_q = 0;  end
                    default: begin m_i = 0; m_q = x; end
                endcase
                m_ph = (m_ph + 1) % 4;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 out_valid", int'(out_valid), m_v);
            chk("R3 out_i", int'(out_i), m_i);
            chk("R4 out_q", int'(out_q), m_q);
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_i", int'(out_i), 0);
        chk("R1 out_q", int'(out_q), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // phase 0 first after reset
        drive(1, 100);
        drive(0, 0);
        chk("R1 first sample I", int'(out_i), 100);
        chk("R6 Q zero slot", int'(out_q), 0);

        // idle gap, then phase 1
        repeat (5) drive(0, 55);
        drive(1, 200);
        drive(0, 0);
        chk("R5 Q after gap", int'(out_q), -200);
        chk("R6 I zero slot", int'(out_i), 0);

        // idle: outputs hold
        drive(0, 77);
        drive(0, 91);
        chk("R8 hold I", int'(out_i), 0);
        chk("R8 hold Q", int'(out_q), -200);

        // phase 2 with most negative
        drive(1, MOST_NEG);
        drive(0, 0);
        chk("R7 I negated most negative", int'(out_i), -MOST_NEG);
        chk("R6 Q zero slot", int'(out_q), 0);

        // phase 3, then wrap to 0 back to back
        drive(1, MOST_NEG);
        drive(1, 300);
        chk("R9 phase3 Q", int'(out_q), MOST_NEG);
        drive(1, MOST_NEG);
        chk("R9 wrap I", int'(out_i), 300);
        drive(0, 0);
        chk("R7 Q negated most negative", int'(out_q), -MOST_NEG);

        // random traffic checked against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            drive(($urandom % 3) != 0, int'($signed(IN_W'($urandom))));
        end
        drive(0, 0);
        drive(0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule